// File: doc/BRIEF.md
# EEPROM Write Protection Gate

This block stands between the serial command decoder and the self-timed nonvolatile write engine of a 2048-byte memory. Each write request arrives as a one-cycle pulse. It is either an array write that carries a starting byte address or a write to the control register. The block accepts the request, holds it until the write engine is idle, and then either grants it or rejects it. Three things decide the outcome: a page-granular lock field, a lock on the control register that combines a pin with an enable bit, and the supervisor reset.

The write engine reports busy for the whole self-timed cycle. The gate never aborts a write that has already been granted, so a write in flight when the supervisor reset rises runs to completion. While the supervisor reset is active, the decoder sees the accept signal low and new requests are not taken in. A request already waiting when the reset rises is rejected when it is decided.

Top module: `wr_protect_gate`

## Requirements
- R1: While rst_n is low at a clock edge, grant and reject are 0 after that edge, no request is held, and bus_accept is 1 whenever sup_rst is 0.
- R2: bus_accept is 0 while sup_rst is 1 or while a request is held. A request presented while bus_accept is 0 is dropped and produces neither grant nor reject.
- R3: A request accepted at clock edge N, with busy low at edge N+1, is decided at edge N+1. Exactly one of grant or reject is then 1 for exactly one cycle, and the two are never 1 together.
- R4: For array writes the page is addr[10:6]. lock_sel 001 locks page 31, 010 locks pages 30-31, 011 locks pages 28-31 and 100 locks pages 24-31. A write whose starting page is locked is rejected and any other write is granted.
- R5: lock_sel codes 000, 110 and 111 lock no page, so an array write to any address is granted.
- R6: lock_sel 101 locks all 32 pages, including page 0.
- R7: A control-register write is rejected when both wp_pin and wpen are 1 at the decision edge. It is granted for the other three combinations, and lock_sel has no effect on it.
- R8: While busy is 1, a held request produces neither grant nor reject. It is decided at the first edge with busy at 0, using the lock_sel, wp_pin, wpen and sup_rst values present at that edge.
- R9: A held request that is decided while sup_rst is 1 is rejected, whatever its kind or address.
- R10: When wr_req and cfg_req are both 1 in the cycle a request is accepted, the array write is taken and the control-register request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| addr | input | 11 | Starting byte address of an array write |
| wr_req | input | 1 | Array write request pulse |
| cfg_req | input | 1 | Control-register write request pulse |
| wp_pin | input | 1 | Write-protect pin level |
| wpen | input | 1 | Control-register protect enable bit |
| lock_sel | input | 3 | Page-lock field |
| sup_rst | input | 1 | Supervisor reset, active high |
| busy | input | 1 | Nonvolatile write engine busy |
| grant | output | 1 | One-cycle pulse: the held write may start |
| reject | output | 1 | One-cycle pulse: the held write is refused |
| bus_accept | output | 1 | A new request would be taken this cycle |

## Verification
Array writes are aimed at the last page just inside and the first page just outside each lock size. This separates an off-by-one error in the locked range from a wrong page-count code, and the spare codes together with the lock-all code are tried at both ends of the array. Control-register writes are sent with all four pin and enable combinations and with a full lock set, which shows that the two locks are independent. The busy and supervisor-reset patterns change the lock or the reset while a request is waiting. A gate that decides at capture time therefore gives a different result from one that decides when busy clears.

// File: rtl/wp_gate_pkg.sv
// Package: shared request kind and lock-field codes for the write protection gate.
// Assumes: lock_sel is a 3-bit field; codes not listed lock nothing.
package wp_gate_pkg;
    typedef enum logic {
        REQ_ARRAY = 1'b0,
        REQ_CFG   = 1'b1
    } req_kind_e;

    localparam logic [2:0] LOCK_NONE = 3'b000;
    localparam logic [2:0] LOCK_TOP1 = 3'b001;
    localparam logic [2:0] LOCK_TOP2 = 3'b010;
    localparam logic [2:0] LOCK_TOP4 = 3'b011;
    localparam logic [2:0] LOCK_TOP8 = 3'b100;
    localparam logic [2:0] LOCK_ALL  = 3'b101;
endpackage

// File: rtl/page_lock_decode.sv
// Module: page_lock_decode
// Decides whether the page holding a byte address is covered by the lock field.
// Locked pages are counted down from the highest page.
// Assumes: at least 8 pages (ADDR_W - PAGE_OFS_W >= 3).
module page_lock_decode
    import wp_gate_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_OFS_W = 6
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        lock_sel,
    output logic              locked
);
    localparam int PAGE_W = ADDR_W - PAGE_OFS_W;
    localparam logic [PAGE_W:0] NUM_PAGES = (PAGE_W+1)'(1 << PAGE_W);

    logic [PAGE_W:0]   lock_cnt;
    logic [PAGE_W-1:0] page;

    assign page = addr[ADDR_W-1:PAGE_OFS_W];

    // Translate the lock code into a number of locked top pages.
    always_comb begin
        case (lock_sel)
            LOCK_TOP1: lock_cnt = (PAGE_W+1)'(1);
            LOCK_TOP2: lock_cnt = (PAGE_W+1)'(2);
            LOCK_TOP4: lock_cnt = (PAGE_W+1)'(4);
            LOCK_TOP8: lock_cnt = (PAGE_W+1)'(8);
            LOCK_ALL:  lock_cnt = NUM_PAGES;
            default:   lock_cnt = '0;
        endcase
    end

    // A page is locked when it lies in the top lock_cnt pages.
    always_comb begin
        locked = (lock_cnt != '0) && ({1'b0, page} >= (NUM_PAGES - lock_cnt));
    end
endmodule

// File: rtl/wr_request_holder.sv
// Module: wr_request_holder
// Takes in one write request when allowed and holds it until the gate decides it.
// Assumes: request inputs are single-cycle pulses from the command decoder.
module wr_request_holder
    import wp_gate_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              cfg_req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sup_rst,
    input  logic              decide,
    output logic              held,
    output req_kind_e         held_kind,
    output logic [ADDR_W-1:0] held_addr,
    output logic              bus_accept
);
    // Open to new requests only outside supervisor reset and with nothing held.
    assign bus_accept = !sup_rst && !held;

    // Capture a request, preferring an array write; release it once decided.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held      <= 1'b0;
            held_kind <= REQ_ARRAY;
            held_addr <= '0;
        end else if (bus_accept && (wr_req || cfg_req)) begin
            held      <= 1'b1;
            held_kind <= wr_req ? REQ_ARRAY : REQ_CFG;
            held_addr <= addr;
        end else if (decide) begin
            held <= 1'b0;
        end
    end
endmodule

// File: rtl/wr_protect_gate.sv
// Module: wr_protect_gate (top)
// Grants or rejects each write toward the nonvolatile engine, based on the page lock,
// the pin-plus-enable lock on the control register and the supervisor reset.
// Assumes: busy stays high for the whole self-timed write; granted writes are never aborted.
module wr_protect_gate
    import wp_gate_pkg::*;
#(
    parameter int ADDR_W     = 11,
    parameter int PAGE_OFS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_req,
    input  logic              cfg_req,
    input  logic              wp_pin,
    input  logic              wpen,
    input  logic [2:0]        lock_sel,
    input  logic              sup_rst,
    input  logic              busy,
    output logic              grant,
    output logic              reject,
    output logic              bus_accept
);
    logic              held;
    req_kind_e         held_kind;
    logic [ADDR_W-1:0] held_addr;
    logic              page_locked;
    logic              decide;
    logic              allow;

    wr_request_holder #(.ADDR_W(ADDR_W)) i_holder (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_req     (wr_req),
        .cfg_req    (cfg_req),
        .addr       (addr),
        .sup_rst    (sup_rst),
        .decide     (decide),
        .held       (held),
        .held_kind  (held_kind),
        .held_addr  (held_addr),
        .bus_accept (bus_accept)
    );

    page_lock_decode #(.ADDR_W(ADDR_W), .PAGE_OFS_W(PAGE_OFS_W)) i_lock (
        .addr     (held_addr),
        .lock_sel (lock_sel),
        .locked   (page_locked)
    );

    // Decide a held request only when the write engine is idle.
    assign decide = held && !busy;

    // Apply reset, page lock or control-register lock to the held request.
    always_comb begin
        if (sup_rst)
            allow = 1'b0;
        else if (held_kind == REQ_ARRAY)
            allow = !page_locked;
        else
            allow = !(wp_pin && wpen);
    end

    // Register the one-cycle grant or reject pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant  <= 1'b0;
            reject <= 1'b0;
        end else begin
            grant  <= decide && allow;
            reject <= decide && !allow;
        end
    end
endmodule

// File: rtl/wp_gate_checker.sv
// Module: wp_gate_checker
// Port-level properties of the write protection gate, bound to the top module.
// Assumes: rst_n is synchronous and active low.
module wp_gate_checker (
    input logic clk,
    input logic rst_n,
    input logic sup_rst,
    input logic busy,
    input logic grant,
    input logic reject,
    input logic bus_accept
);
    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant && reject)); // R3
    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> !grant); // R3
    AST_REJECT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> !reject); // R3
    AST_NO_ACCEPT_IN_SUP_RST: assert property (@(posedge clk) disable iff (!rst_n)
        sup_rst |-> !bus_accept); // R2
    AST_NO_GRANT_AFTER_SUP_RST: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> !$past(sup_rst)); // R9
    AST_NO_RESULT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (grant || reject) |-> !$past(busy)); // R8
endmodule

bind wr_protect_gate wp_gate_checker i_wp_gate_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sup_rst    (sup_rst),
    .busy       (busy),
    .grant      (grant),
    .reject     (reject),
    .bus_accept (bus_accept)
);

// File: tb/test_wr_protect_gate.sv
// Directed bench for wr_protect_gate: one task per scenario, each checking its own results.
module test_wr_protect_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] addr = '0;
    logic        wr_req = 1'b0;
    logic        cfg_req = 1'b0;
    logic        wp_pin = 1'b0;
    logic        wpen = 1'b0;
    logic [2:0]  lock_sel = 3'b000;
    logic        sup_rst = 1'b0;
    logic        busy = 1'b0;
    logic        grant;
    logic        reject;
    logic        bus_accept;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wr_protect_gate i_wr_protect_gate (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_req(wr_req), .cfg_req(cfg_req),
        .wp_pin(wp_pin), .wpen(wpen), .lock_sel(lock_sel), .sup_rst(sup_rst),
        .busy(busy), .grant(grant), .reject(reject), .bus_accept(bus_accept)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Present one request for one cycle; returns at the negedge after the capture edge.
    task automatic send(input bit is_cfg, input bit both, input logic [10:0] a);
        @(negedge clk);
        addr    = a;
        wr_req  = !is_cfg || both;
        cfg_req = is_cfg || both;
        @(negedge clk);
        wr_req  = 1'b0;
        cfg_req = 1'b0;
    endtask

    // Sample the decision one edge later, then confirm the pulse has ended.
    task automatic expect_result(input string tag, input bit exp_grant);
        @(negedge clk);
        chk(grant == exp_grant, tag, "grant", grant, exp_grant);
        chk(reject == !exp_grant, tag, "reject", reject, !exp_grant);
        @(negedge clk);
        chk(!grant && !reject, tag, "pulse end", grant | reject, 0);
    endtask

    task automatic array_case(input string tag, input logic [2:0] sel, input logic [10:0] a, input bit exp_grant);
        @(negedge clk);
        lock_sel = sel;
        send(1'b0, 1'b0, a);
        expect_result(tag, exp_grant);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!grant, "R1", "grant in reset", grant, 0);
        chk(!reject, "R1", "reject in reset", reject, 0);
        chk(bus_accept, "R1", "bus_accept in reset", bus_accept, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_accept, "R1", "bus_accept after reset", bus_accept, 1);
    endtask

    task automatic t_page_lock();
        array_case("R4", 3'b001, 11'h7C0, 1'b0);
        array_case("R4", 3'b001, 11'h7FF, 1'b0);
        array_case("R4", 3'b001, 11'h7BF, 1'b1);
        array_case("R4", 3'b010, 11'h780, 1'b0);
        array_case("R4", 3'b010, 11'h740, 1'b1);
        array_case("R4", 3'b011, 11'h700, 1'b0);
        array_case("R4", 3'b011, 11'h6FF, 1'b1);
        array_case("R4", 3'b100, 11'h600, 1'b0);
        array_case("R4", 3'b100, 11'h5C0, 1'b1);
    endtask

    task automatic t_no_lock_codes();
        array_case("R5", 3'b000, 11'h7FF, 1'b1);
        array_case("R5", 3'b110, 11'h7FF, 1'b1);
        array_case("R5", 3'b111, 11'h7C0, 1'b1);
        array_case("R6", 3'b101, 11'h000, 1'b0);
        array_case("R6", 3'b101, 11'h5FF, 1'b0);
    endtask

    task automatic t_cfg_lock();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            lock_sel = 3'b101;
            wp_pin   = i[0];
            wpen     = i[1];
            send(1'b1, 1'b0, 11'h000);
            expect_result("R7", !(i[0] && i[1]));
        end
        wp_pin = 1'b0;
        wpen   = 1'b0;
    endtask

    task automatic t_busy_hold();
        @(negedge clk);
        lock_sel = 3'b000;
        busy     = 1'b1;
        send(1'b0, 1'b0, 11'h7C0);
        repeat (3) begin
            @(negedge clk);
            chk(!grant && !reject, "R8", "result while busy", grant | reject, 0);
            chk(!bus_accept, "R2", "bus_accept while held", bus_accept, 0);
        end
        wr_req = 1'b1;
        addr   = 11'h000;
        @(negedge clk);
        wr_req   = 1'b0;
        lock_sel = 3'b001;
        busy     = 1'b0;
        expect_result("R8", 1'b0);
        @(negedge clk);
        chk(!grant && !reject, "R2", "dropped request silent", grant | reject, 0);
    endtask

    task automatic t_sup_rst();
        @(negedge clk);
        lock_sel = 3'b000;
        sup_rst  = 1'b1;
        @(negedge clk);
        chk(!bus_accept, "R2", "bus_accept in sup_rst", bus_accept, 0);
        send(1'b0, 1'b0, 11'h010);
        sup_rst = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(!grant && !reject, "R2", "request dropped in sup_rst", grant | reject, 0);
        end
        busy = 1'b1;
        send(1'b1, 1'b0, 11'h000);
        sup_rst = 1'b1;
        @(negedge clk);
        busy = 1'b0;
        expect_result("R9", 1'b0);
        sup_rst = 1'b0;
        @(negedge clk);
        chk(bus_accept, "R2", "bus_accept after sup_rst", bus_accept, 1);
    endtask

    task automatic t_both_requests();
        @(negedge clk);
        lock_sel = 3'b000;
        wp_pin   = 1'b1;
        wpen     = 1'b1;
        send(1'b0, 1'b1, 11'h123);
        expect_result("R10", 1'b1);
        repeat (2) begin
            @(negedge clk);
            chk(!grant && !reject, "R10", "cfg request dropped", grant | reject, 0);
        end
        wp_pin = 1'b0;
        wpen   = 1'b0;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_page_lock();
        t_no_lock_codes();
        t_cfg_lock();
        t_busy_hold();
        t_sup_rst();
        t_both_requests();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule